// File: doc/BRIEF.md
# Bus-Programmable Watchdog Timer

This block is a watchdog timer that software programs through a simple 32-bit register bus. A 32-bit down-counter is loaded from a programmable reload value. It decrements on ticks, and the tick source is selectable. One choice is every cycle of the bus clock. The other is each rising edge of a slower external clock, which is synchronised and edge-detected inside the bus clock domain. When the count reaches zero, a sticky status flag is set. Up to three output pulses then fire: a system reset request, an interrupt request and an external signal. Each of the three has its own enable bit, and all three share one 8-bit width setting.

Software keeps the timer from expiring by writing a 16-bit key to a restart location. The key value is 0x5AB9, written as the full 32-bit word 0x0000_5AB9. That write copies the reload value into the counter. The bus is a plain select/write/address port with a combinational read path. A bus access completes in the cycle it is presented, so there is no back-pressure. The three pulse outputs are level signals that the surrounding logic consumes without a handshake.

Top module: `wdog_timer`

## Requirements
- R1: After reset the counter reads 0x03EF1480, the reload register reads 0x03EF1480, control reads 0, status reads 0, pulse length reads 0xFF and all three outputs are low.
- R2: Byte offsets are: counter 0x00 (read-only), reload 0x04, restart 0x08 (write-only), control 0x0C, status 0x10, status clear 0x14 (write-only), pulse length 0x18. Reads of 0x08, 0x14 and any unmapped offset return 0. Control bits: bit 0 run, bit 1 reset-output enable, bit 2 interrupt-output enable, bit 3 external-output enable, bit 4 tick source (0 bus clock, 1 external clock).
- R3: While control bit 0 is 0, the counter holds its value.
- R4: With bit 0 set and bit 4 clear, the counter decrements once per bus clock cycle. A control write that sets bit 0 takes effect from the following cycle.
- R5: With bits 0 and 4 set, the counter decrements exactly once per rising edge of the external clock. The decrement happens on the third bus clock edge after the rise is driven, and a constant external level causes no decrement.
- R6: Writing exactly 0x00005AB9 to the restart offset loads the reload value into the counter. Any other value written there leaves the counter unchanged.
- R7: When a decrement takes the counter from 1 to 0, status bit 0 becomes 1 on that same edge. The counter then stays at 0 until a restart. Writing 1 to bit 0 of the clear offset sets status to 0.
- R8: On the edge where the counter reaches 0, each output whose enable bit is set goes high. It stays high for (length + 1) bus clock cycles. Outputs whose enable bit is clear stay low.
- R9: A restart write or a control change during a pulse does not shorten the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| ext_clk_in | input | 1 | Slow external tick clock, asynchronous |
| rst_req_o | output | 1 | Reset-request pulse |
| irq_o | output | 1 | Interrupt pulse |
| ext_sig_o | output | 1 | External signal pulse |

## Verification
The hardest situation to reach from the ports is a restart landing while an output pulse is already running. The stimulus must time two bus writes against a count that has just hit zero. The bench does this with a short reload value and a long pulse length. It issues the restart and a control write on the cycles right after expiry, then counts the remaining high cycles. The external tick path is the other hard case. The bench drives the external clock at negedges and samples the counter on the second and third following edges, which pins down the synchroniser latency.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;

  localparam int OFS_COUNT  = 'h00;
  localparam int OFS_RELOAD = 'h04;
  localparam int OFS_KICK   = 'h08;
  localparam int OFS_CTRL   = 'h0C;
  localparam int OFS_STAT   = 'h10;
  localparam int OFS_CLR    = 'h14;
  localparam int OFS_LEN    = 'h18;

  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_5AB9;

  localparam int NUM_OUT = 3;

  // bit 4 src_ext, bits 3..1 out_en (ext, irq, rst), bit 0 run
  typedef struct packed {
    logic               src_ext;
    logic [NUM_OUT-1:0] out_en;
    logic               run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W = 32,
  parameter int LEN_W = 8,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              hit_i,
  output logic [CNT_W-1:0]  reload_o,
  output ctrl_t             ctrl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              kick_o,
  output logic              stat_o
);
  logic wr_en, rd_en;
  logic clr_req;

  assign wr_en   = bus_sel & bus_write;
  assign rd_en   = bus_sel & ~bus_write;
  assign kick_o  = wr_en && (bus_addr == ADDR_W'(OFS_KICK)) && (bus_wdata == KICK_KEY);
  assign clr_req = wr_en && (bus_addr == ADDR_W'(OFS_CLR)) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_o <= RELOAD_INIT;
      ctrl_o   <= '0;
      len_o    <= '1;
      stat_o   <= 1'b0;
    end else begin
      if (wr_en && bus_addr == ADDR_W'(OFS_RELOAD)) reload_o <= bus_wdata[CNT_W-1:0];
      if (wr_en && bus_addr == ADDR_W'(OFS_CTRL))   ctrl_o   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_en && bus_addr == ADDR_W'(OFS_LEN))    len_o    <= bus_wdata[LEN_W-1:0];
      if (hit_i)        stat_o <= 1'b1;
      else if (clr_req) stat_o <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        ADDR_W'(OFS_COUNT):  bus_rdata = DATA_W'(cnt_i);
        ADDR_W'(OFS_RELOAD): bus_rdata = DATA_W'(reload_o);
        ADDR_W'(OFS_CTRL):   bus_rdata = DATA_W'(ctrl_o);
        ADDR_W'(OFS_STAT):   bus_rdata = DATA_W'(stat_o);
        ADDR_W'(OFS_LEN):    bus_rdata = DATA_W'(len_o);
        default:             bus_rdata = '0;
      endcase
    end
  end

  // R7: expiry sets the sticky flag
  a_r7_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> stat_o);
  // R7: clear without a coincident expiry empties the flag
  a_r7_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit_i) |=> !stat_o);
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_in,
  input  logic src_ext,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= ext_clk_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise   = sync_q[SYNC_STAGES-1] & ~last_q;
  assign tick_o = src_ext ? rise : 1'b1;

  // R5: one external edge never yields two consecutive ticks
  a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 32'h03EF1480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic step;

  assign step  = run_i & tick_i & (cnt_o != '0) & ~kick_i;
  assign hit_o = step & (cnt_o == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_o <= RELOAD_INIT;
    else if (kick_i) cnt_o <= reload_i;
    else if (step)   cnt_o <= cnt_o - 1'b1;
  end

  // R3: disabled counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !kick_i) |=> $stable(cnt_o));
  // R6: restart loads the reload value
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_o == $past(reload_i)));
  // R7: zero is sticky until restart
  a_r7_sticky_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '0 && !kick_i) |=> (cnt_o == '0));
  // R7: expiry lands on zero
  a_r7_hit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (cnt_o == '0));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN_W = 8,
  parameter int NUM_OUT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [NUM_OUT-1:0] en_i,
  output logic [NUM_OUT-1:0] pulse_o
);
  logic               act_q;
  logic [LEN_W-1:0]   left_q;
  logic [NUM_OUT-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
      mask_q <= '0;
    end else if (hit_i) begin
      act_q  <= 1'b1;
      left_q <= len_i;
      mask_q <= en_i;
    end else if (act_q) begin
      if (left_q == '0) act_q  <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign pulse_o[i] = act_q & mask_q[i];
    end
  endgenerate

  // R8: expiry starts a pulse
  a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> act_q);
  // R9: a running pulse is never cut before its count is spent
  a_r9_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && left_q != '0) |=> act_q);
  // R8: pulse ends once its count is spent
  a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && left_q == '0 && !hit_i) |=> !act_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W = 32,
  parameter int LEN_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ext_clk_in,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              ext_sig_o
);
  logic [CNT_W-1:0]   cnt, reload;
  logic [LEN_W-1:0]   len;
  ctrl_t              ctrl;
  logic               kick, stat, hit, tick;
  logic [NUM_OUT-1:0] pulses;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_i(cnt), .hit_i(hit), .reload_o(reload), .ctrl_o(ctrl), .len_o(len),
    .kick_o(kick), .stat_o(stat));

  wdog_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in),
    .src_ext(ctrl.src_ext), .tick_o(tick));

  wdog_count #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .reload_i(reload), .run_i(ctrl.run),
    .tick_i(tick), .kick_i(kick), .cnt_o(cnt), .hit_o(hit));

  wdog_pulse #(.LEN_W(LEN_W), .NUM_OUT(NUM_OUT)) u_pulse (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .len_i(len),
    .en_i(ctrl.out_en), .pulse_o(pulses));

  assign rst_req_o = pulses[0];
  assign irq_o     = pulses[1];
  assign ext_sig_o = pulses[2];

  // R1: outputs quiet while no expiry has ever been flagged
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stat |-> (pulses == '0 || $past(stat) || $past(hit)));
endmodule

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  localparam int A_CNT = 'h00, A_REL = 'h04, A_KICK = 'h08, A_CTRL = 'h0C,
                 A_STAT = 'h10, A_CLR = 'h14, A_LEN = 'h18;
  localparam logic [31:0] KEY = 32'h5AB9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_write = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ext_clk_in = 1'b0;
  logic rst_req_o, irq_o, ext_sig_o;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_timer dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_in(ext_clk_in), .rst_req_o(rst_req_o), .irq_o(irq_o), .ext_sig_o(ext_sig_o));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input int a, input logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bread(input int a, output logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 5'(a);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic cyc;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_case(input int L, input int len, input logic [2:0] mask);
    logic [31:0] d;
    bwrite(A_CTRL, 0); bwrite(A_CLR, 1);
    bwrite(A_REL, 32'(L)); bwrite(A_LEN, 32'(len)); bwrite(A_KICK, KEY);
    bread(A_CNT, d); check(d == 32'(L), "R6 restart load", d, L);
    bwrite(A_CTRL, {27'd0, 1'b0, mask, 1'b1});
    for (int k = 1; k <= L + len + 2; k++) begin
      logic [2:0] eo;
      int ec;
      cyc();
      bread(A_CNT, d);
      ec = (k >= L) ? 0 : L - k;
      eo = (k >= L && k <= L + len) ? mask : 3'b000;
      check(d == 32'(ec), "R4 bus-clock decrement", d, ec);
      check({ext_sig_o, irq_o, rst_req_o} == eo, "R8 pulse width/enables",
            {ext_sig_o, irq_o, rst_req_o}, eo);
    end
    bread(A_STAT, d); check(d == 1, "R7 status set", d, 1);
    bwrite(A_CLR, 1);
    bread(A_STAT, d); check(d == 0, "R7 status clear", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    bread(A_CNT, d);  check(d == 32'h03EF1480, "R1 counter", d, 32'h03EF1480);
    bread(A_REL, d);  check(d == 32'h03EF1480, "R1 reload", d, 32'h03EF1480);
    bread(A_CTRL, d); check(d == 0, "R1 control", d, 0);
    bread(A_STAT, d); check(d == 0, "R1 status", d, 0);
    bread(A_LEN, d);  check(d == 32'hFF, "R1 length", d, 32'hFF);
    check({ext_sig_o, irq_o, rst_req_o} == 0, "R1 outputs", {ext_sig_o, irq_o, rst_req_o}, 0);

    // R2 map
    bwrite(A_REL, 32'h1234);
    bread(A_REL, d);  check(d == 32'h1234, "R2 reload rw", d, 32'h1234);
    bwrite(A_CTRL, 32'hFFFF_FFEE);
    bread(A_CTRL, d); check(d == 32'h0E, "R2 control width", d, 32'h0E);
    bwrite(A_CTRL, 0);
    bread(A_KICK, d); check(d == 0, "R2 restart reads zero", d, 0);
    bread(A_CLR, d);  check(d == 0, "R2 clear reads zero", d, 0);
    bread('h1C, d);   check(d == 0, "R2 unmapped", d, 0);
    bwrite(A_CNT, 32'h55);
    bread(A_CNT, d);  check(d == 32'h03EF1480, "R2 counter read-only", d, 32'h03EF1480);

    // R6 key matching
    bwrite(A_REL, 50); bwrite(A_KICK, KEY); bwrite(A_REL, 9);
    bwrite(A_KICK, 32'h5AB8);
    bread(A_CNT, d); check(d == 50, "R6 wrong key ignored", d, 50);
    bwrite(A_KICK, 32'h0001_5AB9);
    bread(A_CNT, d); check(d == 50, "R6 upper bits ignored", d, 50);
    bwrite(A_KICK, KEY);
    bread(A_CNT, d); check(d == 9, "R6 key reloads", d, 9);

    // R3 hold while disabled
    repeat (10) cyc();
    bread(A_CNT, d); check(d == 9, "R3 hold disabled", d, 9);
    bwrite(A_CTRL, 1);   // counts from next edge
    bwrite(A_CTRL, 0);   // one decrement happened on this edge
    repeat (5) cyc();
    bread(A_CNT, d); check(d == 8, "R3 hold after stop", d, 8);

    // R4/R7/R8 sweeps
    for (int L = 1; L <= 5; L++)
      for (int n = 0; n <= 3; n++) run_case(L, n, 3'b111);
    for (int m = 0; m < 8; m++) run_case(2, 1, 3'(m));
    bread(A_CNT, d); check(d == 0, "R7 stays at zero", d, 0);

    // R5 external ticks
    bwrite(A_CTRL, 0); bwrite(A_REL, 20); bwrite(A_KICK, KEY);
    bwrite(A_CTRL, 32'h11);
    repeat (6) cyc();
    bread(A_CNT, d); check(d == 20, "R5 constant level no tick", d, 20);
    for (int n = 1; n <= 4; n++) begin
      ext_clk_in = 1'b1;
      cyc(); cyc();
      bread(A_CNT, d); check(d == 32'(21 - n), "R5 no decrement before third edge", d, 21 - n);
      cyc();
      bread(A_CNT, d); check(d == 32'(20 - n), "R5 decrement on third edge", d, 20 - n);
      cyc(); cyc();
      ext_clk_in = 1'b0;
      repeat (3) cyc();
    end
    bread(A_CNT, d); check(d == 16, "R5 one tick per edge", d, 16);

    // R9 restart and control change mid-pulse
    bwrite(A_CTRL, 0); bwrite(A_CLR, 1);
    bwrite(A_REL, 3); bwrite(A_LEN, 7); bwrite(A_KICK, KEY);
    bwrite(A_CTRL, 32'h0F);
    repeat (3) cyc();
    check(irq_o == 1'b1, "R9 pulse started", irq_o, 1);
    bwrite(A_KICK, KEY);
    bwrite(A_CTRL, 32'h0E);
    for (int k = 6; k <= 10; k++) begin
      cyc();
      check({ext_sig_o, irq_o, rst_req_o} == 3'b111, "R9 pulse not cut",
            {ext_sig_o, irq_o, rst_req_o}, 3'b111);
    end
    cyc();
    check({ext_sig_o, irq_o, rst_req_o} == 3'b000, "R9 pulse ends on time",
          {ext_sig_o, irq_o, rst_req_o}, 3'b000);
    bread(A_CNT, d); check(d == 2, "R9 counter after restart", d, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule